// File: doc/BRIEF.md
# Flash Block Lock Protection Unit

This unit decides whether a program or erase aimed at a boot-block flash array may go ahead. Three sources of protection feed the decision. Each erase block has its own software lock bit. A single permanent lock bit, once set, freezes every block lock bit. An active-low write-protect pin guards the two boot blocks at the top of the map while it is held low. The command decoder in front of the unit passes in lock-configuration commands and array requests as decoded opcodes with a word address. The unit turns the address into a block index itself.

The word address space is 20 bits wide. Thirty-one main blocks of 32K words fill the bottom of the map. Above them sit six parameter blocks of 4K words, and above those two boot blocks of 4K words. Every request gets a registered answer one cycle later. The answer is an erase/program mask over all 39 blocks plus an allow flag. Any refusal also sets a sticky protect error flag, which feeds bit 1 of the device status register. Lock configuration can be read back at identifier addresses. The nonvolatile lock state is modelled as registers that reload from image inputs at reset.

Top module: `flp_lock_unit`

## Requirements
- R1: Block index from word address: if addr[19:15] is not 31, the index is addr[19:15] (main blocks 0..30). Otherwise it is 31 + addr[14:12]. That gives parameter blocks 31..36 at 0xF8000..0xFDFFF and boot blocks 37..38 at 0xFE000..0xFFFFF.
- R2: A command with cmd_op=1 sets the lock bit of the block that contains cmd_addr. Requests see the change from the next cycle on.
- R3: A command with cmd_op=3 clears every block lock bit at once.
- R4: A command with cmd_op=2 sets the permanent lock, which then stays set until reset. While it is set, cmd_op=1 and cmd_op=3 change nothing and set err_protect. Identifier address 0x00003 reads the permanent lock in id_data bit 0.
- R5: When wp_n is low, blocks 37 and 38 count as locked for any request in that same cycle. Parameter and main blocks are not affected, and the stored lock bits are not changed.
- R6: req_op=0 (program) and req_op=1 (block erase) give rsp_valid=1 one cycle later. If the target block is unlocked, rsp_erase_mask has only the target bit set and rsp_allow=1. If it is locked, the mask is zero, rsp_allow=0 and err_protect becomes 1. req_op=3 and idle cycles give rsp_valid=0 and a zero mask.
- R7: req_op=2 (full chip erase) answers with rsp_erase_mask set for every block that is not locked. rsp_allow is 1 when that mask is non-zero. err_protect becomes 1 when any block is skipped.
- R8: err_protect is sticky. cmd_op=4 clears it, but a refusal in the same cycle wins and leaves it set.
- R9: id_data, one cycle after id_addr, carries in bit 0 the stored lock bit of the block containing id_addr when id_addr[1:0]=2. It carries the permanent lock when id_addr=0x00003. Every other address reads 0, and bits 15..1 are always 0. wp_n never shows up in the readback.
- R10: After reset, block lock bits and the permanent lock equal nv_lock_img and nv_perm_img. err_protect and rsp_valid are 0.
- R11: A request and a lock command in the same cycle: the request is judged against the lock state from before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_lock_img | input | 39 | Stored block lock bits, loaded at reset |
| nv_perm_img | input | 1 | Stored permanent lock, loaded at reset |
| wp_n | input | 1 | Boot-block write protect, active low |
| cmd_valid | input | 1 | Lock command strobe |
| cmd_op | input | 3 | 1 set block lock, 2 set permanent lock, 3 clear all locks, 4 clear error |
| cmd_addr | input | 20 | Word address selecting the block for cmd_op=1 |
| req_valid | input | 1 | Array request strobe |
| req_op | input | 2 | 0 program, 1 block erase, 2 full chip erase |
| req_addr | input | 20 | Target word address |
| id_addr | input | 20 | Identifier read address |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_allow | output | 1 | At least one block may be written |
| rsp_erase_mask | output | 39 | Blocks the operation may touch |
| err_protect | output | 1 | Sticky device-protect error |
| id_data | output | 16 | Identifier read data |

## Verification
The bench aims at the address boundaries between the main, parameter and boot regions. A design with a wrong decode would open or refuse the wrong neighbour block. It drives wp_n low against parameter block 36 and the boot blocks: a design that protected too many blocks would refuse block 36, and one that stored the pin into the lock bits would show it in the readback. It places a lock command and a request on the same block in one cycle to expose a design that judges against the new state. It also checks that lock commands issued after the permanent lock bounce off and flag the error, and that a clear-error command loses to a simultaneous refusal.

// File: rtl/flp_pkg.sv
package flp_pkg;
  typedef enum logic [2:0] {
    CMD_NONE       = 3'd0,
    CMD_LOCK_BLK   = 3'd1,
    CMD_LOCK_PERM  = 3'd2,
    CMD_UNLOCK_ALL = 3'd3,
    CMD_CLR_ERR    = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    REQ_PROG       = 2'd0,
    REQ_BLK_ERASE  = 2'd1,
    REQ_CHIP_ERASE = 2'd2,
    REQ_NONE       = 2'd3
  } req_e;
endpackage

// File: rtl/flp_rst_sync.sv
module flp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/flp_blk_decode.sv
module flp_blk_decode #(
  parameter int AW          = 20,
  parameter int NMAIN       = 31,
  parameter int MAIN_SHIFT  = 15,
  parameter int SMALL_SHIFT = 12,
  parameter int IW          = 6
) (
  input  logic [AW-1:0] addr,
  output logic [IW-1:0] idx
);
  localparam int HIW = AW - MAIN_SHIFT;
  localparam int SW  = MAIN_SHIFT - SMALL_SHIFT;

  logic [HIW-1:0] hi;
  logic [SW-1:0]  sub;

  always_comb begin
    hi  = addr[AW-1:MAIN_SHIFT];
    sub = addr[MAIN_SHIFT-1:SMALL_SHIFT];
    if (IW'(hi) < IW'(NMAIN)) idx = IW'(hi);
    else                      idx = IW'(NMAIN) + IW'(sub);
  end
endmodule

// File: rtl/flp_lock_store.sv
module flp_lock_store
  import flp_pkg::*;
#(
  parameter int NBLK = 39,
  parameter int IW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBLK-1:0] nv_lock_img,
  input  logic            nv_perm_img,
  input  logic            cmd_valid,
  input  cmd_e            cmd_op,
  input  logic [IW-1:0]   cmd_idx,
  output logic [NBLK-1:0] lock_cur,
  output logic            perm_cur,
  output logic            cmd_refused
);
  logic            restored_q;
  logic [NBLK-1:0] lock_q, lock_d;
  logic            perm_q, perm_d;
  logic            upd_en;

  // until the first clock after reset the stored image is used directly
  assign lock_cur = restored_q ? lock_q : nv_lock_img;
  assign perm_cur = restored_q ? perm_q : nv_perm_img;

  always_comb begin
    lock_d      = lock_cur;
    perm_d      = perm_cur;
    cmd_refused = 1'b0;
    if (cmd_valid) begin
      unique case (cmd_op)
        CMD_LOCK_BLK: begin
          if (perm_cur) cmd_refused = 1'b1;
          else if (cmd_idx < IW'(NBLK)) lock_d[cmd_idx] = 1'b1;
        end
        CMD_UNLOCK_ALL: begin
          if (perm_cur) cmd_refused = 1'b1;
          else          lock_d = '0;
        end
        CMD_LOCK_PERM: perm_d = 1'b1;
        default: ;
      endcase
    end
  end

  assign upd_en = !restored_q || cmd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restored_q <= 1'b0;
      lock_q     <= '0;
      perm_q     <= 1'b0;
    end else begin
      restored_q <= 1'b1;
      if (upd_en) begin
        lock_q <= lock_d;
        perm_q <= perm_d;
      end
    end
  end
endmodule

// File: rtl/flp_req_judge.sv
module flp_req_judge
  import flp_pkg::*;
#(
  parameter int NBLK   = 39,
  parameter int NPROT  = 37,
  parameter int IW     = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  req_e            req_op,
  input  logic [IW-1:0]   req_idx,
  input  logic            wp_n,
  input  logic [NBLK-1:0] lock_cur,
  input  logic            cmd_refused,
  input  logic            clr_err,
  output logic            rsp_valid,
  output logic            rsp_allow,
  output logic [NBLK-1:0] rsp_mask,
  output logic            err_protect
);
  logic [NBLK-1:0] eff_lock;
  logic [NBLK-1:0] mask_d;
  logic            act_d, deny_d, err_d, err_en, set_err;

  // pin-based protection covers only indexes at or above NPROT
  for (genvar i = 0; i < NBLK; i++) begin : g_eff
    if (i >= NPROT) begin : g_pin
      assign eff_lock[i] = lock_cur[i] | ~wp_n;
    end else begin : g_sw
      assign eff_lock[i] = lock_cur[i];
    end
  end

  always_comb begin
    mask_d = '0;
    act_d  = 1'b0;
    deny_d = 1'b0;
    if (req_valid) begin
      unique case (req_op)
        REQ_PROG, REQ_BLK_ERASE: begin
          act_d = 1'b1;
          if (eff_lock[req_idx]) deny_d = 1'b1;
          else                   mask_d[req_idx] = 1'b1;
        end
        REQ_CHIP_ERASE: begin
          act_d  = 1'b1;
          mask_d = ~eff_lock;
          deny_d = |eff_lock;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    set_err = deny_d | cmd_refused;
    err_en  = set_err | clr_err;
    err_d   = set_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_allow   <= 1'b0;
      rsp_mask    <= '0;
      err_protect <= 1'b0;
    end else begin
      rsp_valid <= act_d;
      rsp_allow <= |mask_d;
      rsp_mask  <= mask_d;
      if (err_en) err_protect <= err_d;
    end
  end
endmodule

// File: rtl/flp_id_read.sv
module flp_id_read #(
  parameter int AW   = 20,
  parameter int DW   = 16,
  parameter int NBLK = 39,
  parameter int IW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   id_addr,
  input  logic [IW-1:0]   id_idx,
  input  logic [NBLK-1:0] lock_cur,
  input  logic            perm_cur,
  output logic [DW-1:0]   id_data
);
  localparam logic [AW-1:0] PERM_ADDR = AW'(3);

  logic bit_d, bit_q;

  always_comb begin
    if (id_addr == PERM_ADDR)      bit_d = perm_cur;
    else if (id_addr[1:0] == 2'b10) bit_d = lock_cur[id_idx];
    else                            bit_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_d;
  end

  assign id_data = {{(DW-1){1'b0}}, bit_q};
endmodule

// File: rtl/flp_lock_unit.sv
module flp_lock_unit
  import flp_pkg::*;
#(
  parameter  int AW          = 20,
  parameter  int DW          = 16,
  parameter  int NMAIN       = 31,
  parameter  int NPARAM      = 6,
  parameter  int NBOOT       = 2,
  parameter  int MAIN_SHIFT  = 15,
  parameter  int SMALL_SHIFT = 12,
  localparam int NBLK        = NMAIN + NPARAM + NBOOT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBLK-1:0] nv_lock_img,
  input  logic            nv_perm_img,
  input  logic            wp_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [AW-1:0]   cmd_addr,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [AW-1:0]   id_addr,
  output logic            rsp_valid,
  output logic            rsp_allow,
  output logic [NBLK-1:0] rsp_erase_mask,
  output logic            err_protect,
  output logic [DW-1:0]   id_data
);
  localparam int IW    = $clog2(NBLK + 1);
  localparam int NPROT = NMAIN + NPARAM;

  logic            rst_sn;
  logic [IW-1:0]   cmd_idx, req_idx, id_idx;
  logic [NBLK-1:0] lock_cur;
  logic            perm_cur;
  logic            cmd_refused;
  logic            clr_err;
  cmd_e            cmd_e_op;
  req_e            req_e_op;

  assign cmd_e_op = cmd_e'(cmd_op);
  assign req_e_op = req_e'(req_op);
  assign clr_err  = cmd_valid && (cmd_e_op == CMD_CLR_ERR);

  flp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  flp_blk_decode #(.AW(AW), .NMAIN(NMAIN), .MAIN_SHIFT(MAIN_SHIFT),
                   .SMALL_SHIFT(SMALL_SHIFT), .IW(IW))
    u_dec_cmd (.addr(cmd_addr), .idx(cmd_idx));

  flp_blk_decode #(.AW(AW), .NMAIN(NMAIN), .MAIN_SHIFT(MAIN_SHIFT),
                   .SMALL_SHIFT(SMALL_SHIFT), .IW(IW))
    u_dec_req (.addr(req_addr), .idx(req_idx));

  flp_blk_decode #(.AW(AW), .NMAIN(NMAIN), .MAIN_SHIFT(MAIN_SHIFT),
                   .SMALL_SHIFT(SMALL_SHIFT), .IW(IW))
    u_dec_id (.addr(id_addr), .idx(id_idx));

  flp_lock_store #(.NBLK(NBLK), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_sn),
    .nv_lock_img(nv_lock_img), .nv_perm_img(nv_perm_img),
    .cmd_valid(cmd_valid), .cmd_op(cmd_e_op), .cmd_idx(cmd_idx),
    .lock_cur(lock_cur), .perm_cur(perm_cur), .cmd_refused(cmd_refused)
  );

  flp_req_judge #(.NBLK(NBLK), .NPROT(NPROT), .IW(IW)) u_judge (
    .clk(clk), .rst_n(rst_sn),
    .req_valid(req_valid), .req_op(req_e_op), .req_idx(req_idx),
    .wp_n(wp_n), .lock_cur(lock_cur),
    .cmd_refused(cmd_refused), .clr_err(clr_err),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_mask(rsp_erase_mask),
    .err_protect(err_protect)
  );

  flp_id_read #(.AW(AW), .DW(DW), .NBLK(NBLK), .IW(IW)) u_id (
    .clk(clk), .rst_n(rst_sn),
    .id_addr(id_addr), .id_idx(id_idx),
    .lock_cur(lock_cur), .perm_cur(perm_cur),
    .id_data(id_data)
  );
endmodule

// File: rtl/flp_lock_unit_chk.sv
module flp_lock_unit_chk #(
  parameter int AW          = 20,
  parameter int NBLK        = 39,
  parameter int NBOOT       = 2,
  parameter int SMALL_SHIFT = 12
) (
  input logic            clk,
  input logic            rst_sn,
  input logic            wp_n,
  input logic            req_valid,
  input logic [1:0]      req_op,
  input logic [AW-1:0]   req_addr,
  input logic            rsp_valid,
  input logic            rsp_allow,
  input logic [NBLK-1:0] rsp_erase_mask,
  input logic            err_protect,
  input logic [NBLK-1:0] lock_cur,
  input logic            perm_cur
);
  localparam logic [AW-1:0] BOOT_BASE = AW'((1 << AW) - (NBOOT << SMALL_SHIFT));

  // R5: pin low refuses single-block requests to the boot region
  assert_boot_wp_deny_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(req_valid && !wp_n && (req_op < 2'd2) && (req_addr >= BOOT_BASE))
      |-> (rsp_valid && !rsp_allow));

  // R6: a refused answer always comes with the protect error
  assert_deny_sets_err_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (rsp_valid && !rsp_allow) |-> err_protect);

  // R6: single-block operations touch at most one block
  assert_single_target_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(req_valid && (req_op < 2'd2)) |-> $onehot0(rsp_erase_mask));

  // R6: no response means nothing may be touched
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    !rsp_valid |-> (rsp_erase_mask == '0 && !rsp_allow));

  // R7: chip erase never reaches boot blocks while the pin is low
  assert_chip_skips_boot_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(req_valid && req_op == 2'd2 && !wp_n)
      |-> (rsp_erase_mask[NBLK-1 -: NBOOT] == '0));

  // R4: permanent lock never falls back
  assert_perm_sticky_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(perm_cur) |-> perm_cur);

  // R4: lock bits frozen under permanent lock
  assert_locks_frozen_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    perm_cur |=> $stable(lock_cur));
endmodule

bind flp_lock_unit flp_lock_unit_chk #(
  .AW(AW), .NBLK(NBLK), .NBOOT(NBOOT), .SMALL_SHIFT(SMALL_SHIFT)
) u_chk (
  .clk(clk), .rst_sn(rst_sn), .wp_n(wp_n),
  .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
  .rsp_erase_mask(rsp_erase_mask), .err_protect(err_protect),
  .lock_cur(lock_cur), .perm_cur(perm_cur)
);

// File: tb/tb_flp_lock_unit.sv
`timescale 1ns/1ps
module tb_flp_lock_unit;
  localparam int NB = 39;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NB-1:0] nv_lock_img;
  logic          nv_perm_img;
  logic          wp_n;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [19:0]   cmd_addr;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [19:0]   req_addr;
  logic [19:0]   id_addr;
  logic          rsp_valid, rsp_allow, err_protect;
  logic [NB-1:0] rsp_erase_mask;
  logic [15:0]   id_data;

  int total = 0;
  int bad   = 0;

  logic [NB-1:0] m_lock;
  logic          m_perm;
  logic          m_err;

  always #2 clk = ~clk;

  flp_lock_unit dut (
    .clk(clk), .rst_n(rst_n), .nv_lock_img(nv_lock_img), .nv_perm_img(nv_perm_img),
    .wp_n(wp_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .id_addr(id_addr),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_erase_mask(rsp_erase_mask),
    .err_protect(err_protect), .id_data(id_data)
  );

  function automatic int blk_of(input logic [19:0] a);
    if (a[19:15] != 5'd31) return int'(a[19:15]);
    return 31 + int'(a[14:12]);
  endfunction

  function automatic logic [19:0] base_of(input int b);
    if (b < 31) return 20'(b << 15);
    return 20'(32'hF8000 + ((b - 31) << 12));
  endfunction

  function automatic logic [19:0] rand_addr_in(input int b);
    int sz;
    sz = (b < 31) ? 32768 : 4096;
    return base_of(b) + 20'($urandom % sz);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic cv, input logic [2:0] cop, input logic [19:0] caddr,
                      input logic rv, input logic [1:0] rop, input logic [19:0] raddr,
                      input logic wp, input logic [19:0] iaddr, input string tag);
    logic [NB-1:0] eff, e_mask;
    logic          e_valid, e_deny, refused, e_err;
    logic [15:0]   e_id;
    int b;
    cmd_valid = cv; cmd_op = cop; cmd_addr = caddr;
    req_valid = rv; req_op = rop; req_addr = raddr;
    wp_n = wp; id_addr = iaddr;
    for (int i = 0; i < NB; i++) eff[i] = m_lock[i] | ((i >= 37) && !wp);
    e_mask = '0; e_deny = 1'b0; e_valid = rv && (rop != 2'd3);
    if (rv && rop < 2'd2) begin
      b = blk_of(raddr);
      e_deny = eff[b];
      if (!eff[b]) e_mask[b] = 1'b1;
    end else if (rv && rop == 2'd2) begin
      e_mask = ~eff;
      e_deny = |eff;
    end
    refused = cv && m_perm && (cop == 3'd1 || cop == 3'd3);
    e_err = (e_deny || refused) ? 1'b1 : (cv && cop == 3'd4) ? 1'b0 : m_err;
    e_id = '0;
    if (iaddr == 20'h3) e_id[0] = m_perm;
    else if (iaddr[1:0] == 2'b10) e_id[0] = m_lock[blk_of(iaddr)];
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, 64'(rsp_valid), 64'(e_valid));
    check({tag, " allow"}, 64'(rsp_allow), 64'(|e_mask));
    check({tag, " mask"},  64'(rsp_erase_mask), 64'(e_mask));
    check("R8 err_protect", 64'(err_protect), 64'(e_err));
    check("R9 id_data", 64'(id_data), 64'(e_id));
    if (cv && !m_perm && cop == 3'd1) m_lock[blk_of(caddr)] = 1'b1;
    if (cv && !m_perm && cop == 3'd3) m_lock = '0;
    if (cv && cop == 3'd2) m_perm = 1'b1;
    m_err = e_err;
  endtask

  task automatic idle(input string tag);
    tick(1'b0, 3'd0, 20'h0, 1'b0, 2'd3, 20'h0, 1'b1, 20'h0, tag);
  endtask

  task automatic do_reset(input logic [NB-1:0] img, input logic pimg);
    rst_n = 1'b0;
    nv_lock_img = img; nv_perm_img = pimg;
    cmd_valid = 0; cmd_op = 0; cmd_addr = 0;
    req_valid = 0; req_op = 2'd3; req_addr = 0;
    wp_n = 1'b1; id_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_lock = img; m_perm = pimg; m_err = 1'b0;
    repeat (3) idle("R10 idle after reset");
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got hung expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NB-1:0] img;
    void'($urandom(32'h5EED_0017));
    img = {7'b1010011, 32'h8421_0F0F};
    do_reset(img, 1'b0);

    // R10 / R9 / R1: read every block's stored lock back
    for (int b = 0; b < NB; b++)
      tick(1'b0, 3'd0, 20'h0, 1'b0, 2'd3, 20'h0, 1'b1, base_of(b) + 20'h2, "R10 readback");
    tick(1'b0, 3'd0, 20'h0, 1'b0, 2'd3, 20'h0, 1'b1, 20'h3, "R4 perm readback");

    // R1: decode boundaries
    tick(1'b0, 0, 0, 1'b1, 2'd0, 20'hF7FFF, 1'b1, 20'hF7FFE, "R1 top of block 30");
    tick(1'b0, 0, 0, 1'b1, 2'd0, 20'hF8000, 1'b1, 20'hF8002, "R1 base of block 31");
    tick(1'b0, 0, 0, 1'b1, 2'd1, 20'hFDFFF, 1'b1, 20'hFDFFE, "R1 top of block 36");
    tick(1'b0, 0, 0, 1'b1, 2'd1, 20'hFE000, 1'b1, 20'hFE002, "R1 base of block 37");
    tick(1'b0, 0, 0, 1'b1, 2'd0, 20'hFFFFF, 1'b1, 20'hFF002, "R1 top of block 38");

    // R3 then R5: clear all, pin low against boot and parameter blocks
    tick(1'b1, 3'd3, 20'h0, 1'b0, 2'd3, 20'h0, 1'b1, 20'h0, "R3 clear all");
    tick(1'b1, 3'd4, 20'h0, 1'b1, 2'd0, 20'hFE010, 1'b0, 20'hFE002, "R5 boot 37 pin low");
    tick(1'b0, 3'd0, 20'h0, 1'b1, 2'd1, 20'hFD000, 1'b0, 20'hFF002, "R5 param 36 pin low");
    tick(1'b0, 3'd0, 20'h0, 1'b1, 2'd2, 20'h0, 1'b0, 20'hFF002, "R7 chip erase pin low");
    tick(1'b0, 3'd0, 20'h0, 1'b1, 2'd0, 20'hFF123, 1'b1, 20'h0, "R5 boot 38 pin high");

    // R11 / R2: lock and program same block in one cycle, then again
    tick(1'b1, 3'd1, 20'h40000, 1'b1, 2'd0, 20'h41234, 1'b1, 20'h40002, "R11 same cycle");
    tick(1'b0, 3'd0, 20'h0, 1'b1, 2'd0, 20'h45678, 1'b1, 20'h40002, "R2 locked next cycle");
    tick(1'b0, 3'd0, 20'h0, 1'b1, 2'd2, 20'h0, 1'b1, 20'h0, "R7 chip erase skip");

    // R8: clear error, and clear losing to a refusal
    tick(1'b1, 3'd4, 20'h0, 1'b0, 2'd3, 20'h0, 1'b1, 20'h0, "R8 clear");
    tick(1'b1, 3'd4, 20'h0, 1'b1, 2'd0, 20'h40000, 1'b1, 20'h0, "R8 set wins");
    tick(1'b1, 3'd4, 20'h0, 1'b1, 2'd3, 20'h40000, 1'b1, 20'h0, "R6 op3 no response");

    // random phase without permanent lock
    for (int n = 0; n < 1500; n++) begin
      logic [2:0] cop;
      int k;
      k = $urandom % 10;
      cop = (k < 3) ? 3'd1 : (k < 4) ? 3'd3 : (k < 6) ? 3'd4 : 3'd0;
      tick(($urandom % 2) == 0, cop, rand_addr_in($urandom % NB),
           ($urandom % 4) != 0, 2'($urandom % 4), rand_addr_in($urandom % NB),
           ($urandom % 3) != 0,
           (($urandom % 8) == 0) ? 20'h3 : rand_addr_in($urandom % NB), "R6 random");
    end

    // R4: permanent lock freezes lock bits
    tick(1'b1, 3'd4, 20'h0, 1'b0, 2'd3, 20'h0, 1'b1, 20'h0, "R8 pre clear");
    tick(1'b1, 3'd1, 20'h08000, 1'b0, 2'd3, 20'h0, 1'b1, 20'h0, "R2 lock block 1");
    tick(1'b1, 3'd2, 20'h0, 1'b0, 2'd3, 20'h0, 1'b1, 20'h3, "R4 set perm");
    tick(1'b1, 3'd3, 20'h0, 1'b0, 2'd3, 20'h0, 1'b1, 20'h3, "R4 clear refused");
    tick(1'b1, 3'd1, 20'h10000, 1'b1, 2'd0, 20'h08100, 1'b1, 20'h08002, "R4 set refused");
    tick(1'b0, 3'd0, 20'h0, 1'b1, 2'd0, 20'h10100, 1'b1, 20'h10002, "R4 block 2 unchanged");

    // reset with permanent lock stored, random traffic with all commands
    img = {7'b0110100, 32'h1357_9BDF};
    do_reset(img, 1'b1);
    tick(1'b0, 3'd0, 20'h0, 1'b0, 2'd3, 20'h0, 1'b1, 20'h3, "R10 perm from image");
    for (int n = 0; n < 600; n++) begin
      tick(($urandom % 2) == 0, 3'($urandom % 5), rand_addr_in($urandom % NB),
           ($urandom % 4) != 0, 2'($urandom % 4), rand_addr_in($urandom % NB),
           ($urandom % 3) != 0, rand_addr_in($urandom % NB) | 20'h2, "R4 random frozen");
    end

    // fresh image, then random traffic including the permanent lock command
    do_reset('0, 1'b0);
    for (int n = 0; n < 400; n++) begin
      tick(($urandom % 3) == 0, 3'($urandom % 5), rand_addr_in($urandom % NB),
           ($urandom % 3) != 0, 2'($urandom % 4), rand_addr_in($urandom % NB),
           ($urandom % 2) != 0, rand_addr_in($urandom % NB), "R7 random mixed");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule